// File: doc/BRIEF.md
# Floating-Point Control Register File with Aliased Views

This block keeps the single 32-bit control and status word of a floating-point unit. It serves the coprocessor control moves that the integer pipeline issues. A combinational read port takes a 5-bit selector and returns a 32-bit word. A write port takes a selector, a data word and a strobe, and the write lands at the next rising clock edge.

Besides the full status word, three narrow alias windows read and update parts of that same storage. They do not hold any state of their own:
- The condition-code window packs the eight condition bits into one byte.
- The exception window shows the cause and sticky flag fields.
- The enables window shows the trap enables, the rounding mode and the flush-to-zero control.

A fixed revision word is also readable. The `alias_en` input hides all three windows when it is low.

Top module: `fpu_ctrl_regs`

## Requirements
- R1: Selector 0 reads the parameter `REV_ID`. Writes to selector 0 have no effect.
- R2: Selector 31 reads the whole status word. A write to selector 31 stores `wr_data` with bits 22:18 forced to zero. Those bits always read as zero.
- R3: Selector 25 reads status bit 23 in bit 0, status bits 31:25 in bits 7:1, and zero in bits 31:8.
- R4: A write to selector 25 puts `wr_data[0]` into status bit 23 and `wr_data[7:1]` into status bits 31:25. All other status bits are left unchanged.
- R5: Selector 28 reads status bits 11:7 (trap enables) and 1:0 (rounding mode) in place, and status bit 24 (flush-to-zero) in bit 2. All other bits read as zero.
- R6: A write to selector 28 replaces status bits 11:7 and 1:0 with the same bits of `wr_data`, and status bit 24 with `wr_data[2]`. All other status bits are left unchanged.
- R7: Selector 26 reads status bits 17:12 (cause) and 6:2 (sticky flags) in place. All other bits read as zero.
- R8: A write to selector 26 replaces status bits 17:12 and 6:2 from `wr_data`. All other status bits are left unchanged.
- R9: With `alias_en` low, selectors 25, 26 and 28 read as zero and writes to them leave the status word unchanged.
- R10: Every selector other than 0, 25, 26, 28 and 31 reads as zero, and writes to it leave the status word unchanged.
- R11: An active-low reset clears the status word to zero.
- R12: A write becomes visible only after the clock edge that takes it. A read in the same cycle as the write returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alias_en | input | 1 | Makes the three alias windows visible |
| rd_sel | input | 5 | Read selector |
| rd_data | output | 32 | Read data, combinational |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 5 | Write selector |
| wr_data | input | 32 | Write data |

## Verification
The assertions check on every cycle:
- the revision read;
- that the reserved bits stay zero;
- the full-word write result;
- the merge of a condition-code write;
- that disabled alias windows and unknown selectors read as zero and leave the status word untouched;
- the clear after reset.

The bit repacking of the enables and exception windows, and how successive writes through different windows combine, are shown only by the bench's scenarios. The same holds for the value seen in the cycle of a write. In those scenarios the bench compares each read against its own model of the status word.

// File: rtl/fpu_ctrl_regs.sv
module fpu_ctrl_regs #(
  parameter logic [31:0] REV_ID = 32'h0001_0A00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        alias_en,
  input  logic [4:0]  rd_sel,
  output logic [31:0] rd_data,
  input  logic        wr_en,
  input  logic [4:0]  wr_sel,
  input  logic [31:0] wr_data
);

  localparam logic [4:0] SEL_REV  = 5'd0;
  localparam logic [4:0] SEL_CC   = 5'd25;
  localparam logic [4:0] SEL_EXC  = 5'd26;
  localparam logic [4:0] SEL_ENA  = 5'd28;
  localparam logic [4:0] SEL_FULL = 5'd31;

  localparam int CC0_BIT = 23;
  localparam int FTZ_BIT = 24;
  localparam int FTZ_VIEW_BIT = 2;

  localparam logic [31:0] RSVD_MASK = 32'h007C_0000;
  localparam logic [31:0] EXC_MASK  = 32'h0003_F07C;
  localparam logic [31:0] ENA_MASK  = 32'h0000_0F83;

  logic [31:0] status_q;
  logic [31:0] status_d;
  logic [31:0] cc_view;
  logic [31:0] exc_view;
  logic [31:0] ena_view;

  assign cc_view  = {24'b0, status_q[31:25], status_q[CC0_BIT]};
  assign exc_view = status_q & EXC_MASK;
  assign ena_view = (status_q & ENA_MASK) |
                    (32'(status_q[FTZ_BIT]) << FTZ_VIEW_BIT);

  always_comb begin
    rd_data = '0;
    case (rd_sel)
      SEL_REV:  rd_data = REV_ID;
      SEL_FULL: rd_data = status_q;
      SEL_CC:   if (alias_en) rd_data = cc_view;
      SEL_EXC:  if (alias_en) rd_data = exc_view;
      SEL_ENA:  if (alias_en) rd_data = ena_view;
      default:  rd_data = '0;
    endcase
  end

  always_comb begin
    status_d = status_q;
    if (wr_en) begin
      case (wr_sel)
        SEL_FULL: status_d = wr_data & ~RSVD_MASK;
        SEL_CC: if (alias_en) begin
          status_d[CC0_BIT] = wr_data[0];
          status_d[31:25]   = wr_data[7:1];
        end
        SEL_EXC: if (alias_en)
          status_d = (status_q & ~EXC_MASK) | (wr_data & EXC_MASK);
        SEL_ENA: if (alias_en) begin
          status_d = (status_q & ~ENA_MASK) | (wr_data & ENA_MASK);
          status_d[FTZ_BIT] = wr_data[FTZ_VIEW_BIT];
        end
        default: status_d = status_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

endmodule

// File: rtl/fpu_ctrl_regs_chk.sv
module fpu_ctrl_regs_chk #(
  parameter logic [31:0] REV_ID = 32'h0001_0A00
) (
  input logic        clk,
  input logic        rst_n,
  input logic        alias_en,
  input logic [4:0]  rd_sel,
  input logic [31:0] rd_data,
  input logic        wr_en,
  input logic [4:0]  wr_sel,
  input logic [31:0] wr_data,
  input logic [31:0] status_q
);

  logic rd_known, wr_known, wr_alias;
  assign rd_known = rd_sel inside {5'd0, 5'd25, 5'd26, 5'd28, 5'd31};
  assign wr_known = wr_sel inside {5'd25, 5'd26, 5'd28, 5'd31};
  assign wr_alias = wr_sel inside {5'd25, 5'd26, 5'd28};

  // R1
  rev_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel == 5'd0 |-> rd_data == REV_ID);

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[22:18] == 5'b0);

  // R2
  full_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 5'd31 |=>
      status_q == ($past(wr_data) & 32'hFF83_FFFF));

  // R4
  cc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && alias_en && wr_sel == 5'd25 |=>
      status_q[23] == $past(wr_data[0]) &&
      status_q[31:25] == $past(wr_data[7:1]) &&
      status_q[22:0] == $past(status_q[22:0]) &&
      status_q[24] == $past(status_q[24]));

  // R9
  alias_off_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alias_en && rd_sel inside {5'd25, 5'd26, 5'd28} |-> rd_data == 32'b0);

  // R9
  alias_off_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !alias_en && wr_alias |=> $stable(status_q));

  // R10
  other_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_known |-> rd_data == 32'b0);

  // R10
  other_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_known |=> $stable(status_q));

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> status_q == 32'b0);

endmodule

bind fpu_ctrl_regs fpu_ctrl_regs_chk #(.REV_ID(REV_ID)) chk_i (
  .clk(clk), .rst_n(rst_n), .alias_en(alias_en), .rd_sel(rd_sel),
  .rd_data(rd_data), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .status_q(status_q)
);

// File: tb/fpu_ctrl_regs_tb_top.sv
module fpu_ctrl_regs_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] REV = 32'h0001_0A00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alias_en = 1'b1;
  logic [4:0] rd_sel = '0;
  logic [31:0] rd_data;
  logic wr_en = 1'b0;
  logic [4:0] wr_sel = '0;
  logic [31:0] wr_data = '0;

  int n_run = 0;
  int n_fail = 0;
  logic [31:0] mstat = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpu_ctrl_regs #(.REV_ID(REV)) dut_i (
    .clk(clk), .rst_n(rst_n), .alias_en(alias_en), .rd_sel(rd_sel),
    .rd_data(rd_data), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data)
  );

  function automatic logic [31:0] exp_rd(input logic [4:0] s);
    logic [31:0] v = '0;
    case (s)
      5'd0:  v = REV;
      5'd31: v = mstat;
      5'd25: if (alias_en) begin
        v[0] = mstat[23];
        for (int i = 1; i < 8; i++) v[i] = mstat[24 + i];
      end
      5'd26: if (alias_en) begin
        v[6:2] = mstat[6:2];
        v[17:12] = mstat[17:12];
      end
      5'd28: if (alias_en) begin
        v[1:0] = mstat[1:0];
        v[11:7] = mstat[11:7];
        v[2] = mstat[24];
      end
      default: v = '0;
    endcase
    return v;
  endfunction

  task automatic model_wr(input logic [4:0] s, input logic [31:0] d);
    case (s)
      5'd31: begin mstat = d; mstat[22:18] = '0; end
      5'd25: if (alias_en) begin
        mstat[23] = d[0];
        for (int i = 1; i < 8; i++) mstat[24 + i] = d[i];
      end
      5'd26: if (alias_en) begin
        mstat[6:2] = d[6:2];
        mstat[17:12] = d[17:12];
      end
      5'd28: if (alias_en) begin
        mstat[1:0] = d[1:0];
        mstat[11:7] = d[11:7];
        mstat[24] = d[2];
      end
      default: ;
    endcase
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [4:0] s);
    rd_sel = s;
    #1;
    check(req, rd_data, exp_rd(s));
  endtask

  task automatic wr(input logic [4:0] s, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(s, d);
  endtask

  task automatic t_reset;
    rd_chk("R11", 5'd31);
    rd_chk("R11", 5'd25);
    rd_chk("R11", 5'd28);
  endtask

  task automatic t_rev;
    rd_chk("R1", 5'd0);
    wr(5'd0, 32'h1234_5678);
    rd_chk("R1", 5'd0);
    rd_chk("R1", 5'd31);
  endtask

  task automatic t_full;
    wr(5'd31, 32'hFFFF_FFFF);
    rd_chk("R2", 5'd31);
    check("R2", rd_data[22:18], 5'b0);
    wr(5'd31, 32'h5A5A_A5A5);
    rd_chk("R2", 5'd31);
  endtask

  task automatic t_cc;
    wr(5'd31, 32'h0080_0000);
    rd_chk("R3", 5'd25);
    wr(5'd31, 32'hA100_0F0F);
    rd_chk("R3", 5'd25);
    wr(5'd25, 32'hFFFF_FF5A);
    rd_chk("R4", 5'd31);
    rd_chk("R4", 5'd25);
    wr(5'd25, 32'h0000_0001);
    rd_chk("R4", 5'd31);
  endtask

  task automatic t_ena;
    wr(5'd31, 32'h0100_0FFF);
    rd_chk("R5", 5'd28);
    wr(5'd31, 32'hFEFF_F07C);
    rd_chk("R5", 5'd28);
    wr(5'd28, 32'hFFFF_F07E);
    rd_chk("R6", 5'd31);
    wr(5'd28, 32'h0000_0F81);
    rd_chk("R6", 5'd31);
    rd_chk("R6", 5'd28);
  endtask

  task automatic t_exc;
    wr(5'd31, 32'hFFFF_FFFF);
    rd_chk("R7", 5'd26);
    wr(5'd26, 32'h0000_0000);
    rd_chk("R8", 5'd31);
    wr(5'd26, 32'hFFFF_FFFF);
    rd_chk("R8", 5'd31);
    rd_chk("R7", 5'd26);
  endtask

  task automatic t_alias_off;
    wr(5'd31, 32'h5A83_A5A5);
    alias_en = 1'b0;
    rd_chk("R9", 5'd25);
    rd_chk("R9", 5'd26);
    rd_chk("R9", 5'd28);
    wr(5'd25, 32'h0000_00FF);
    wr(5'd26, 32'h0000_0000);
    wr(5'd28, 32'hFFFF_FFFF);
    rd_chk("R9", 5'd31);
    alias_en = 1'b1;
    rd_chk("R9", 5'd25);
  endtask

  task automatic t_other;
    wr(5'd31, 32'h1234_5678);
    for (int s = 1; s < 31; s++) begin
      if (s != 25 && s != 26 && s != 28) begin
        wr(5'(s), 32'hFFFF_FFFF);
        rd_chk("R10", 5'(s));
      end
    end
    rd_chk("R10", 5'd31);
  endtask

  task automatic t_same_cycle;
    logic [31:0] old;
    wr(5'd31, 32'h0000_0003);
    old = mstat;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 5'd31; wr_data = 32'hF000_0000; rd_sel = 5'd31;
    #1;
    check("R12", rd_data, old);
    @(negedge clk);
    wr_en = 1'b0;
    model_wr(5'd31, 32'hF000_0000);
    rd_chk("R12", 5'd31);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_rev();
    t_full();
    t_cc();
    t_ena();
    t_exc();
    t_alias_off();
    t_other();
    t_same_cycle();
    wr(5'd31, 32'hFFFF_FFFF);
    @(negedge clk);
    rst_n = 1'b0;
    mstat = '0;
    #1;
    rd_chk("R11", 5'd31);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule